// File: doc/BRIEF.md
# Packed SIMD Execution Unit

This block is one execution lane for packed integer arithmetic. Each issue carries an opcode, two 128-bit source operands and a valid strobe. The block returns a 128-bit result and a result-valid strobe after a latency that is fixed for each opcode.

Three operations read only the low 64 bits of each operand and finish in one cycle:
- a wrapping add on four signed 16-bit lanes;
- a rounded average on eight unsigned bytes;
- a dual pack of low halfwords.

Two operations read the full 128 bits and finish in two cycles:
- a pair of four-element signed 16-bit dot products;
- four parallel signed 32-bit multiplies.

A new operation may be issued every cycle. Results come out in issue order, except where a one-cycle operation would finish in the same cycle as a two-cycle operation.

Results of 64-bit operations are placed in the low 64 bits of the result, and the upper 64 bits are zero. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `simd_exec_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first result, `out_valid` is 0 and `out_result` is 0.
- R2: Opcode 0 (add) computes result bits [16i+15:16i] = (a[16i+15:16i] + b[16i+15:16i]) mod 2^16 for i = 0..3, with no carry between lanes and result bits [127:64] = 0. Operand bits [127:64] have no effect.
- R3: Opcode 1 (average) computes result byte i = (a_byte_i + b_byte_i + 1) >> 1 for i = 0..7, with unsigned bytes taken from bits [8i+7:8i] and no carry between bytes. Result bits [127:64] = 0.
- R4: Opcode 2 (pack) computes, for k = 0,1, result[32k+31:32k+16] = a[32k+15:32k] and result[32k+15:32k] = b[32k+15:32k]. Result bits [127:64] = 0.
- R5: Opcode 3 (dot product) computes result[32k+31:32k] = sum over i = 0..3 of signed a_h[4k+i] * signed b_h[4k+i], wrapped modulo 2^32, for k = 0,1. Halfword j is bits [16j+15:16j], and result bits [127:64] = 0.
- R6: Opcode 4 (multiply) computes result[32i+31:32i] = low 32 bits of signed a[32i+31:32i] * signed b[32i+31:32i], for i = 0..3.
- R7: For opcodes 0-2, `out_valid` rises exactly one clock after the edge that samples `in_valid`. For opcodes 3-4, it rises exactly two clocks after that edge.
- R8: An issue with opcode 5, 6 or 7 produces no `out_valid` and leaves `out_result` unchanged.
- R9: While `out_valid` is 0, `out_result` keeps its previous value.
- R10: A two-cycle operation issued at edge t and a one-cycle operation issued at edge t+1 would both finish at edge t+2. In that case only the two-cycle result appears, and the one-cycle operation is dropped.
- R11: Operations issued on consecutive cycles with no collision each produce their own result, one per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 3 | Opcode: 0 add, 1 average, 2 pack, 3 dot, 4 multiply |
| in_a | input | 128 | First source operand |
| in_b | input | 128 | Second source operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 128 | Packed result |

## Verification
The bench targets lane boundaries with operands whose sums or products overflow a lane:
- A design that leaks a carry across 16-bit or byte lanes corrupts the neighbouring lane.
- A design that drops the rounding term in the average gets the 0xFE+0x01 and 0xFF+0x00 bytes wrong.

For the dot product, one group of four products sums to exactly 2^32 and another group mixes negative terms. These expose any missing sign extension or a sum that saturates instead of wrapping. The multiply vectors include -2^31 * -1 and 65537^2, so a product that truncates the wrong half shows up.

Timing corners complete the list:
- back-to-back issue of each class;
- a dot product followed at once by an add, where the add must vanish;
- reserved opcodes;
- a reset in the middle of an operation.

A design that delivered both colliding results, misordered them, or let a stale result reappear is reported.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int unsigned OP_W     = 3;
  localparam int unsigned WIDE_W   = 128;
  localparam int unsigned NARROW_W = 64;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DOT_GRP  = 4;

  localparam int unsigned ADD_N  = NARROW_W / HALF_W;
  localparam int unsigned AVG_N  = NARROW_W / BYTE_W;
  localparam int unsigned PACK_N = NARROW_W / WORD_W;
  localparam int unsigned PROD_N = WIDE_W / HALF_W;
  localparam int unsigned MUL_N  = WIDE_W / WORD_W;
  localparam int unsigned DOT_N  = PROD_N / DOT_GRP;

  typedef enum logic [OP_W-1:0] {
    OP_ADD16  = 3'd0,
    OP_AVGU8  = 3'd1,
    OP_PACKLO = 3'd2,
    OP_DOT16  = 3'd3,
    OP_MUL32  = 3'd4
  } simd_op_e;

  function automatic logic op_is_fast(input logic [OP_W-1:0] op);
    return (op == OP_ADD16) || (op == OP_AVGU8) || (op == OP_PACKLO);
  endfunction

  function automatic logic op_is_slow(input logic [OP_W-1:0] op);
    return (op == OP_DOT16) || (op == OP_MUL32);
  endfunction

endpackage

// File: rtl/simd_fast_lanes.sv
module simd_fast_lanes
  import simd_pkg::*;
(
  input  logic [OP_W-1:0]     op,
  input  logic [NARROW_W-1:0] a,
  input  logic [NARROW_W-1:0] b,
  output logic [NARROW_W-1:0] res
);

  logic [NARROW_W-1:0] add_r;
  logic [NARROW_W-1:0] avg_r;
  logic [NARROW_W-1:0] pack_r;

  // Per-lane add: each lane is its own adder, so no carry crosses a lane edge.
  generate
    for (genvar i = 0; i < ADD_N; i++) begin : g_add
      assign add_r[i*HALF_W +: HALF_W] = a[i*HALF_W +: HALF_W] + b[i*HALF_W +: HALF_W];
    end

    for (genvar i = 0; i < AVG_N; i++) begin : g_avg
      logic [BYTE_W:0] sum9;
      assign sum9 = {1'b0, a[i*BYTE_W +: BYTE_W]} + {1'b0, b[i*BYTE_W +: BYTE_W]} + 1'b1;
      assign avg_r[i*BYTE_W +: BYTE_W] = sum9[BYTE_W:1];
    end

    for (genvar k = 0; k < PACK_N; k++) begin : g_pack
      assign pack_r[k*WORD_W +: WORD_W] = {a[k*WORD_W +: HALF_W], b[k*WORD_W +: HALF_W]};
    end
  endgenerate

  always_comb begin
    case (op)
      OP_ADD16:  res = add_r;
      OP_AVGU8:  res = avg_r;
      OP_PACKLO: res = pack_r;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/simd_prod_gen.sv
module simd_prod_gen
  import simd_pkg::*;
(
  input  logic [OP_W-1:0]          op,
  input  logic [WIDE_W-1:0]        a,
  input  logic [WIDE_W-1:0]        b,
  output logic [PROD_N*WORD_W-1:0] prods
);

  logic [PROD_N*WORD_W-1:0] dot_p;
  logic [PROD_N*WORD_W-1:0] mul_p;

  generate
    for (genvar j = 0; j < PROD_N; j++) begin : g_prod
      logic signed [WORD_W-1:0] xa;
      logic signed [WORD_W-1:0] xb;
      assign xa = WORD_W'($signed(a[j*HALF_W +: HALF_W]));
      assign xb = WORD_W'($signed(b[j*HALF_W +: HALF_W]));
      assign dot_p[j*WORD_W +: WORD_W] = xa * xb;

      if (j < MUL_N) begin : g_mul
        // The low half of a product is the same for signed and unsigned operands.
        assign mul_p[j*WORD_W +: WORD_W] = a[j*WORD_W +: WORD_W] * b[j*WORD_W +: WORD_W];
      end else begin : g_nomul
        assign mul_p[j*WORD_W +: WORD_W] = '0;
      end
    end
  endgenerate

  assign prods = (op == OP_MUL32) ? mul_p : dot_p;

endmodule

// File: rtl/simd_reduce.sv
module simd_reduce
  import simd_pkg::*;
(
  input  logic [OP_W-1:0]          op,
  input  logic [PROD_N*WORD_W-1:0] prods,
  output logic [WIDE_W-1:0]        res
);

  logic [DOT_N*WORD_W-1:0] dot_r;

  generate
    for (genvar k = 0; k < DOT_N; k++) begin : g_sum
      logic [WORD_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < DOT_GRP; i++) begin
          acc = acc + prods[(k*DOT_GRP + i)*WORD_W +: WORD_W];
        end
      end
      assign dot_r[k*WORD_W +: WORD_W] = acc;
    end
  endgenerate

  always_comb begin
    if (op == OP_MUL32) begin
      res = prods[MUL_N*WORD_W-1:0];
    end else begin
      res = '0;
      res[DOT_N*WORD_W-1:0] = dot_r;
    end
  end

endmodule

// File: rtl/simd_exec_unit.sv
module simd_exec_unit
  import simd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [WIDE_W-1:0] in_a,
  input  logic [WIDE_W-1:0] in_b,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_result
);

  localparam int unsigned SYNC_N = 2;

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_ok = rst_sync_q[SYNC_N-1];

  // Datapath pieces.
  logic [NARROW_W-1:0]      fast_res;
  logic [PROD_N*WORD_W-1:0] prod_c;
  logic [WIDE_W-1:0]        slow_res;

  // First stage of the two-cycle operations.
  logic                     s1_valid_q, s1_valid_n;
  logic [OP_W-1:0]          s1_op_q;
  logic [PROD_N*WORD_W-1:0] s1_prod_q;

  // Output stage.
  logic              out_valid_q, out_valid_n;
  logic              out_load;
  logic [WIDE_W-1:0] out_res_q, out_res_n;

  simd_fast_lanes i_fast (
    .op (in_op),
    .a  (in_a[NARROW_W-1:0]),
    .b  (in_b[NARROW_W-1:0]),
    .res(fast_res)
  );

  simd_prod_gen i_prod (
    .op   (in_op),
    .a    (in_a),
    .b    (in_b),
    .prods(prod_c)
  );

  simd_reduce i_reduce (
    .op   (s1_op_q),
    .prods(s1_prod_q),
    .res  (slow_res)
  );

  // Next-state logic. A finishing two-cycle operation owns the output stage.
  always_comb begin
    s1_valid_n = in_valid && op_is_slow(in_op);
    out_res_n  = out_res_q;
    if (s1_valid_q) begin
      out_res_n = slow_res;
    end else if (in_valid && op_is_fast(in_op)) begin
      out_res_n = '0;
      out_res_n[NARROW_W-1:0] = fast_res;
    end
    out_valid_n = s1_valid_q || (in_valid && op_is_fast(in_op));
    out_load    = out_valid_n;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      s1_valid_q  <= 1'b0;
      s1_op_q     <= '0;
      s1_prod_q   <= '0;
      out_valid_q <= 1'b0;
      out_res_q   <= '0;
    end else begin
      s1_valid_q  <= s1_valid_n;
      if (s1_valid_n) begin
        s1_op_q   <= in_op;
        s1_prod_q <= prod_c;
      end
      out_valid_q <= out_valid_n;
      if (out_load) begin
        out_res_q <= out_res_n;
      end
    end
  end

  assign out_valid  = out_valid_q;
  assign out_result = out_res_q;

  // Checks on the pipeline timing.
  assert_fast_latency_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && op_is_fast(in_op) && !s1_valid_q) |=> out_valid);

  assert_slow_latency_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && op_is_slow(in_op)) |=> ##1 out_valid);

  assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !op_is_fast(in_op) && !op_is_slow(in_op) && !s1_valid_q) |=> !out_valid);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    !out_valid |-> $stable(out_result));

  assert_collision_slow_wins_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && op_is_slow(in_op)) |=> (in_valid && op_is_fast(in_op)) |=> out_valid);

endmodule

// File: tb/test_simd_exec_unit.sv
module test_simd_exec_unit;

  typedef struct packed {
    logic [2:0]   op;
    logic         slow;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    // R2 add with wrap at lane edges
    '{3'd0, 1'b0, 128'h7FFF_0001_FFFF_1234, 128'h0001_0002_0001_1111,
      128'h8000_0003_0000_2345},
    // R3 rounded byte average
    '{3'd1, 1'b0, 128'hFF00_0102_FFFE_1003, 128'hFF01_0304_0001_2005,
      128'hFF01_0203_8080_1804},
    // R4 dual low-halfword pack
    '{3'd2, 1'b0, 128'hAAAA_1111_BBBB_2222, 128'hCCCC_3333_DDDD_4444,
      128'h1111_3333_2222_4444},
    // R5 dot product with signed terms
    '{3'd3, 1'b1, 128'h8000_0003_0002_FFFF_0004_0003_0002_0001,
      128'h0002_0004_0005_0003_0001_0001_0001_0001,
      128'hFFFF_0013_0000_000A},
    // R5 dot product that wraps modulo 2^32
    '{3'd3, 1'b1, 128'h8000_8000_8000_8000_8000_8000_8000_8000,
      128'h7FFF_7FFF_7FFF_7FFF_8000_8000_8000_8000,
      128'h0002_0000_0000_0000},
    // R6 multiply lanes
    '{3'd4, 1'b1, 128'h80000000_00010000_FFFFFFFF_00000003,
      128'hFFFFFFFF_00010000_00000007_00000005,
      128'h80000000_00000000_FFFFFFF9_0000000F},
    // R6 multiply keeps the low half
    '{3'd4, 1'b1, 128'h00000000_00000000_00010001_00000000,
      128'h00000000_00000000_00010001_00000000,
      128'h00000000_00000000_00020001_00000000},
    // R2 upper operand bits ignored, upper result zero
    '{3'd0, 1'b0, 128'hDEADBEEF_CAFEF00D_00010001_00010001,
      128'h12345678_9ABCDEF0_00020002_00020002,
      128'h00000000_00000000_00030003_00030003}
  };

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   in_op;
  logic [127:0] in_a;
  logic [127:0] in_b;
  logic         out_valid;
  logic [127:0] out_result;

  int errors;
  int checks;
  int cycles;

  simd_exec_unit i_simd_exec_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_result(out_result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 5000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [127:0] a,
                       input logic [127:0] b);
    in_valid = v;
    in_op    = op;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 3'd0, '0, '0);
    repeat (3) @(negedge clk);
    chk_bit("R1 valid in reset", out_valid, 1'b0);
    chk_res("R1 result in reset", out_result, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R1 valid after release", out_valid, 1'b0);
    chk_res("R1 result after release", out_result, '0);
  endtask

  initial begin
    errors = 0;
    checks = 0;
    cycles = 0;
    rst_n  = 1'b0;
    drive(1'b0, 3'd0, '0, '0);
    @(negedge clk);
    do_reset();

    // Table walk: one issue, then check at the opcode's latency (R7).
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      drive(1'b1, TBL[n].op, TBL[n].a, TBL[n].b);
      @(negedge clk);
      drive(1'b0, 3'd0, '0, '0);
      if (TBL[n].slow) begin
        chk_bit("R7 slow not early", out_valid, 1'b0);
        @(negedge clk);
      end
      chk_bit("R7 valid at latency", out_valid, 1'b1);
      chk_res("R2-6 table result", out_result, TBL[n].exp);
      @(negedge clk);
      chk_bit("R7 single pulse", out_valid, 1'b0);
      chk_res("R9 hold after pulse", out_result, TBL[n].exp);
    end

    // R8: reserved opcodes are silent and leave the result alone.
    for (int op = 5; op < 8; op++) begin
      drive(1'b1, 3'(op), TBL[0].a, TBL[0].b);
      @(negedge clk);
      drive(1'b0, 3'd0, '0, '0);
      chk_bit("R8 no valid", out_valid, 1'b0);
      chk_res("R8 result unchanged", out_result, TBL[NV-1].exp);
      @(negedge clk);
      chk_bit("R8 no late valid", out_valid, 1'b0);
    end

    // R11: back-to-back one-cycle operations.
    drive(1'b1, TBL[1].op, TBL[1].a, TBL[1].b);
    @(negedge clk);
    chk_res("R11 first fast", out_result, TBL[1].exp);
    drive(1'b1, TBL[2].op, TBL[2].a, TBL[2].b);
    @(negedge clk);
    drive(1'b0, 3'd0, '0, '0);
    chk_bit("R11 second fast valid", out_valid, 1'b1);
    chk_res("R11 second fast", out_result, TBL[2].exp);
    @(negedge clk);

    // R11: back-to-back multiplies.
    drive(1'b1, TBL[5].op, TBL[5].a, TBL[5].b);
    @(negedge clk);
    drive(1'b1, TBL[6].op, TBL[6].a, TBL[6].b);
    @(negedge clk);
    drive(1'b0, 3'd0, '0, '0);
    chk_bit("R11 first mul valid", out_valid, 1'b1);
    chk_res("R11 first mul", out_result, TBL[5].exp);
    @(negedge clk);
    chk_bit("R11 second mul valid", out_valid, 1'b1);
    chk_res("R11 second mul", out_result, TBL[6].exp);
    @(negedge clk);
    chk_bit("R11 pipe empty", out_valid, 1'b0);

    // R10: dot product then add; only the dot product result appears.
    drive(1'b1, TBL[3].op, TBL[3].a, TBL[3].b);
    @(negedge clk);
    drive(1'b1, TBL[0].op, TBL[0].a, TBL[0].b);
    @(negedge clk);
    drive(1'b0, 3'd0, '0, '0);
    chk_bit("R10 slow result valid", out_valid, 1'b1);
    chk_res("R10 slow result wins", out_result, TBL[3].exp);
    @(negedge clk);
    chk_bit("R10 fast op dropped", out_valid, 1'b0);
    chk_res("R10 no late fast result", out_result, TBL[3].exp);

    // R1: reset in the middle of a multiply.
    drive(1'b1, TBL[5].op, TBL[5].a, TBL[5].b);
    @(negedge clk);
    drive(1'b0, 3'd0, '0, '0);
    rst_n = 1'b0;
    #1;
    chk_bit("R1 mid-op reset valid", out_valid, 1'b0);
    chk_res("R1 mid-op reset result", out_result, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_bit("R1 no result after reset", out_valid, 1'b0);
    chk_res("R1 result cleared", out_result, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule